// File: doc/BRIEF.md
# Five-by-five integer matrix multiplier

This block multiplies two square 5x5 matrices of signed 8-bit integers and delivers the 25 entries of the product as 16-bit words. Software, or a neighbouring controller, first fills two local operand banks through simple address/data write ports. It then raises `start` for one cycle while the block reports `idle`. The block streams the results out through an address/data write port and announces the end of the run with a one-cycle `done` pulse.

The left operand bank returns a whole row in one read, and the right operand bank returns a whole column in one read. Both are indexed by a single sequencer that walks the output grid row by row. Five multipliers work side by side, and a registered two-level adder tree sums their products. As a result, one output element leaves the block every clock once the four-stage pipeline has filled, and a complete run takes a fixed 29 cycles.

Top module: `mxm_engine`

## Requirements
- R1: While reset is applied, and in the cycles after reset until the first start, `idle` is 1, `done` is 0 and `res_we` is 0.
- R2: A write with `lhs_we` (or `rhs_we`) high stores the data at row r, column c, where the address is r*5+c. Writes to addresses 25 to 31 change no stored element.
- R3: Operand writes made while `idle` is 0 are dropped. The banks keep the values they held when the run began.
- R4: The result written for row i, column j is the sum over k of lhs[i][k]*rhs[k][j], using two's-complement products. The sum is kept in 16 bits and wraps on overflow (five products of -128*-128 give 16384).
- R5: Each run writes exactly 25 results on 25 consecutive cycles. The results come in row-major order with `res_addr` = i*5+j, counting up from 0 to 24.
- R6: `start` is only accepted at a clock edge where `idle` is 1, and `idle` is 0 from the next cycle on. A `start` seen while a run is active is ignored and causes no second run.
- R7: With the accepting edge counted as edge 0, `res_we` first goes high just after edge 4 and stays high through the cycle after edge 28.
- R8: `done` is high for exactly one cycle, just after edge 29, which is the cycle after the last result write. `idle` is 1 from that same cycle.
- R9: The operand banks keep their contents across runs, so a second start with no new writes reproduces the same 25 results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begins a run when sampled high while idle |
| idle | output | 1 | High when no run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| lhs_we | input | 1 | Write enable for the left operand bank |
| lhs_addr | input | 5 | Left operand element address, r*5+c |
| lhs_wdata | input | 8 | Left operand element, signed |
| rhs_we | input | 1 | Write enable for the right operand bank |
| rhs_addr | input | 5 | Right operand element address, r*5+c |
| rhs_wdata | input | 8 | Right operand element, signed |
| res_we | output | 1 | Result write strobe |
| res_addr | output | 5 | Result element address, i*5+j |
| res_wdata | output | 16 | Result element, two's complement |

## Verification
A fault in the sequencer's row or column counter shows up within one pipeline depth, four cycles later. It appears as a result address out of step, or as a value taken from the wrong row or column, and so as a wrong word at a known address. A lost or extra pipeline valid bit moves the first write, the write count or the `done` cycle. These are compared against fixed cycle numbers counted from the accepting edge. Anti-identity, triangular, ramp, saturating and mixed-sign operand patterns make every lane of the adder tree and the wrap-around behaviour visible in at least one result word.

// File: rtl/mxm_pkg.sv
package mxm_pkg;
  localparam int unsigned MXM_DIM   = 5;
  localparam int unsigned MXM_EW    = 8;
  localparam int unsigned MXM_RW    = 16;
  localparam int unsigned MXM_DEPTH = 4;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_ISSUE = 2'd1,
    SQ_DRAIN = 2'd2
  } seq_state_t;
endpackage

// File: rtl/mxm_rst_sync.sv
module mxm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/mxm_bank.sv
// Operand storage; ROW_WISE selects whether the read port returns a row or a column.
module mxm_bank #(
  parameter int unsigned N        = mxm_pkg::MXM_DIM,
  parameter int unsigned EW       = mxm_pkg::MXM_EW,
  parameter bit          ROW_WISE = 1'b1,
  localparam int unsigned IW      = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            wr_en,
  input  logic [IW-1:0]   wr_row,
  input  logic [IW-1:0]   wr_col,
  input  logic [EW-1:0]   wr_data,
  input  logic [IW-1:0]   rd_sel,
  output logic [N*EW-1:0] rd_vec
);
  logic [EW-1:0] cell_q [N][N];

  for (genvar r = 0; r < N; r++) begin : g_row
    for (genvar c = 0; c < N; c++) begin : g_col
      logic hit;
      assign hit = wr_en && (wr_row == IW'(r)) && (wr_col == IW'(c));
      always_ff @(posedge clk) begin
        if (hit) cell_q[r][c] <= wr_data;
      end
    end
  end

  if (ROW_WISE) begin : g_rd_row
    for (genvar k = 0; k < N; k++) begin : g_k
      assign rd_vec[k*EW +: EW] = cell_q[rd_sel][k];
    end
  end else begin : g_rd_col
    for (genvar k = 0; k < N; k++) begin : g_k
      assign rd_vec[k*EW +: EW] = cell_q[k][rd_sel];
    end
  end
endmodule

// File: rtl/mxm_seq.sv
module mxm_seq #(
  parameter int unsigned N   = mxm_pkg::MXM_DIM,
  localparam int unsigned CNT = N * N,
  localparam int unsigned AW  = $clog2(CNT),
  localparam int unsigned IW  = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          fin,
  output logic          idle,
  output logic          done,
  output logic          iss_valid,
  output logic          iss_last,
  output logic [IW-1:0] iss_row,
  output logic [IW-1:0] iss_col,
  output logic [AW-1:0] iss_addr
);
  import mxm_pkg::*;

  seq_state_t    state_q, state_d;
  logic [IW-1:0] row_q, row_d, col_q, col_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          done_q, done_d;

  always_comb begin
    state_d = state_q;
    row_d   = row_q;
    col_d   = col_q;
    addr_d  = addr_q;
    done_d  = 1'b0;
    unique case (state_q)
      SQ_IDLE: begin
        if (start) begin
          state_d = SQ_ISSUE;
          row_d   = '0;
          col_d   = '0;
          addr_d  = '0;
        end
      end
      SQ_ISSUE: begin
        if (addr_q == AW'(CNT - 1)) begin
          state_d = SQ_DRAIN;
        end else begin
          addr_d = addr_q + 1'b1;
          if (col_q == IW'(N - 1)) begin
            col_d = '0;
            row_d = row_q + 1'b1;
          end else begin
            col_d = col_q + 1'b1;
          end
        end
      end
      SQ_DRAIN: begin
        if (fin) begin
          state_d = SQ_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      row_q   <= '0;
      col_q   <= '0;
      addr_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      row_q   <= row_d;
      col_q   <= col_d;
      addr_q  <= addr_d;
      done_q  <= done_d;
    end
  end

  assign idle      = (state_q == SQ_IDLE);
  assign done      = done_q;
  assign iss_valid = (state_q == SQ_ISSUE);
  assign iss_last  = iss_valid && (addr_q == AW'(CNT - 1));
  assign iss_row   = row_q;
  assign iss_col   = col_q;
  assign iss_addr  = addr_q;

  assert_idle_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && start) |=> !idle);
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> idle);
endmodule

// File: rtl/mxm_dot_tree.sv
// Four registered stages: operands, products, pair sums, final sum.
module mxm_dot_tree #(
  parameter int unsigned N   = mxm_pkg::MXM_DIM,
  parameter int unsigned EW  = mxm_pkg::MXM_EW,
  parameter int unsigned RW  = mxm_pkg::MXM_RW,
  parameter int unsigned AW  = 5,
  localparam int unsigned HN = (N + 1) / 2,
  localparam int unsigned ST = mxm_pkg::MXM_DEPTH
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic            in_last,
  input  logic [AW-1:0]   in_addr,
  input  logic [N*EW-1:0] in_lhs,
  input  logic [N*EW-1:0] in_rhs,
  output logic            out_valid,
  output logic            out_last,
  output logic [AW-1:0]   out_addr,
  output logic [RW-1:0]   out_sum
);
  logic [ST-1:0] vld_q, lst_q;
  logic [AW-1:0] adr_q [ST];

  logic [N*EW-1:0] s1_lhs_q, s1_rhs_q;
  logic [RW-1:0]   prod_d [N];
  logic [RW-1:0]   s2_prod_q [N];
  logic [RW-1:0]   half_d [HN];
  logic [RW-1:0]   s3_half_q [HN];
  logic [RW-1:0]   sum_d;
  logic [RW-1:0]   s4_sum_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      lst_q <= '0;
    end else begin
      vld_q <= {vld_q[ST-2:0], in_valid};
      lst_q <= {lst_q[ST-2:0], in_valid && in_last};
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) adr_q[0] <= in_addr;
  end
  for (genvar s = 1; s < ST; s++) begin : g_adr
    always_ff @(posedge clk) begin
      if (vld_q[s-1]) adr_q[s] <= adr_q[s-1];
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      s1_lhs_q <= in_lhs;
      s1_rhs_q <= in_rhs;
    end
  end

  for (genvar k = 0; k < N; k++) begin : g_mul
    logic [RW-1:0] ext_l, ext_r;
    assign ext_l     = {{(RW-EW){s1_lhs_q[k*EW+EW-1]}}, s1_lhs_q[k*EW +: EW]};
    assign ext_r     = {{(RW-EW){s1_rhs_q[k*EW+EW-1]}}, s1_rhs_q[k*EW +: EW]};
    assign prod_d[k] = ext_l * ext_r;
    always_ff @(posedge clk) begin
      if (vld_q[0]) s2_prod_q[k] <= prod_d[k];
    end
  end

  for (genvar g = 0; g < HN; g++) begin : g_half
    if (2*g + 1 < N) begin : g_pair
      assign half_d[g] = s2_prod_q[2*g] + s2_prod_q[2*g+1];
    end else begin : g_odd
      assign half_d[g] = s2_prod_q[2*g];
    end
    always_ff @(posedge clk) begin
      if (vld_q[1]) s3_half_q[g] <= half_d[g];
    end
  end

  always_comb begin
    sum_d = '0;
    for (int g = 0; g < HN; g++) sum_d = sum_d + s3_half_q[g];
  end

  always_ff @(posedge clk) begin
    if (vld_q[2]) s4_sum_q <= sum_d;
  end

  assign out_valid = vld_q[ST-1];
  assign out_last  = lst_q[ST-1];
  assign out_addr  = adr_q[ST-1];
  assign out_sum   = s4_sum_q;

  assert_burst_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last) |=> !out_valid);
endmodule

// File: rtl/mxm_engine.sv
module mxm_engine #(
  parameter int unsigned N  = mxm_pkg::MXM_DIM,
  parameter int unsigned EW = mxm_pkg::MXM_EW,
  parameter int unsigned RW = mxm_pkg::MXM_RW,
  localparam int unsigned CNT = N * N,
  localparam int unsigned AW  = $clog2(CNT),
  localparam int unsigned IW  = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          idle,
  output logic          done,
  input  logic          lhs_we,
  input  logic [AW-1:0] lhs_addr,
  input  logic [EW-1:0] lhs_wdata,
  input  logic          rhs_we,
  input  logic [AW-1:0] rhs_addr,
  input  logic [EW-1:0] rhs_wdata,
  output logic          res_we,
  output logic [AW-1:0] res_addr,
  output logic [RW-1:0] res_wdata
);
  logic          rst_s;
  logic          fin;
  logic          iss_valid, iss_last;
  logic [IW-1:0] iss_row, iss_col;
  logic [AW-1:0] iss_addr;
  logic [N*EW-1:0] row_vec, col_vec;

  logic          lhs_ok, rhs_ok;
  logic [AW-1:0] lhs_rfull, lhs_cfull, rhs_rfull, rhs_cfull;

  mxm_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s)
  );

  // Writes land only while idle and only inside the 5x5 grid.
  assign lhs_ok    = lhs_we && idle && (lhs_addr < AW'(CNT));
  assign rhs_ok    = rhs_we && idle && (rhs_addr < AW'(CNT));
  assign lhs_rfull = lhs_addr / AW'(N);
  assign lhs_cfull = lhs_addr % AW'(N);
  assign rhs_rfull = rhs_addr / AW'(N);
  assign rhs_cfull = rhs_addr % AW'(N);

  mxm_bank #(.N(N), .EW(EW), .ROW_WISE(1'b1)) u_lhs (
    .clk     (clk),
    .wr_en   (lhs_ok),
    .wr_row  (lhs_rfull[IW-1:0]),
    .wr_col  (lhs_cfull[IW-1:0]),
    .wr_data (lhs_wdata),
    .rd_sel  (iss_row),
    .rd_vec  (row_vec)
  );

  mxm_bank #(.N(N), .EW(EW), .ROW_WISE(1'b0)) u_rhs (
    .clk     (clk),
    .wr_en   (rhs_ok),
    .wr_row  (rhs_rfull[IW-1:0]),
    .wr_col  (rhs_cfull[IW-1:0]),
    .wr_data (rhs_wdata),
    .rd_sel  (iss_col),
    .rd_vec  (col_vec)
  );

  mxm_seq #(.N(N)) u_seq (
    .clk       (clk),
    .rst_n     (rst_s),
    .start     (start),
    .fin       (fin),
    .idle      (idle),
    .done      (done),
    .iss_valid (iss_valid),
    .iss_last  (iss_last),
    .iss_row   (iss_row),
    .iss_col   (iss_col),
    .iss_addr  (iss_addr)
  );

  mxm_dot_tree #(.N(N), .EW(EW), .RW(RW), .AW(AW)) u_tree (
    .clk       (clk),
    .rst_n     (rst_s),
    .in_valid  (iss_valid),
    .in_last   (iss_last),
    .in_addr   (iss_addr),
    .in_lhs    (row_vec),
    .in_rhs    (col_vec),
    .out_valid (res_we),
    .out_last  (fin),
    .out_addr  (res_addr),
    .out_sum   (res_wdata)
  );

  assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_s)
    (res_we && $past(res_we)) |-> (res_addr == $past(res_addr) + 1'b1));
  assert_addr_range_R5: assert property (@(posedge clk) disable iff (!rst_s)
    res_we |-> (res_addr < AW'(CNT)));
  assert_done_after_last_R8: assert property (@(posedge clk) disable iff (!rst_s)
    done |-> ($past(res_we) && $past(res_addr) == AW'(CNT - 1)));
  assert_busy_write_R7: assert property (@(posedge clk) disable iff (!rst_s)
    res_we |-> !idle);
endmodule

// File: tb/sim_mxm_engine.sv
module sim_mxm_engine;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic        idle, done;
  logic        lhs_we, rhs_we;
  logic [4:0]  lhs_addr, rhs_addr;
  logic [7:0]  lhs_wdata, rhs_wdata;
  logic        res_we;
  logic [4:0]  res_addr;
  logic [15:0] res_wdata;

  int checks = 0;
  int fails  = 0;

  int          ma [5][5];
  int          mb [5][5];
  logic [15:0] got [25];
  int          seen [25];

  // Each entry: {left pattern, right pattern}
  localparam logic [7:0] CASES [6] = '{
    {4'd0, 4'd1}, {4'd3, 4'd4}, {4'd2, 4'd2},
    {4'd5, 4'd3}, {4'd4, 4'd0}, {4'd1, 4'd5}
  };

  always #4 clk = ~clk;

  mxm_engine u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .idle(idle), .done(done),
    .lhs_we(lhs_we), .lhs_addr(lhs_addr), .lhs_wdata(lhs_wdata),
    .rhs_we(rhs_we), .rhs_addr(rhs_addr), .rhs_wdata(rhs_wdata),
    .res_we(res_we), .res_addr(res_addr), .res_wdata(res_wdata)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int pat(input int mode, input int r, input int c);
    case (mode)
      0: return (r + c == 4) ? 1 : 0;
      1: return (c >= r) ? 1 : 0;
      2: return -128;
      3: return r * 5 + c - 12;
      4: return ((r + c) % 2 == 1) ? -7 * (c + 1) : 9 * (r + 1);
      default: return 127;
    endcase
  endfunction

  function automatic logic [15:0] expect_at(input int i, input int j);
    int s = 0;
    for (int k = 0; k < 5; k++) s += ma[i][k] * mb[k][j];
    return 16'(s);
  endfunction

  task automatic load(input int mode_l, input int mode_r);
    for (int a = 0; a < 25; a++) begin
      @(negedge clk);
      lhs_we = 1'b1; lhs_addr = 5'(a); lhs_wdata = 8'(pat(mode_l, a / 5, a % 5));
      rhs_we = 1'b1; rhs_addr = 5'(a); rhs_wdata = 8'(pat(mode_r, a / 5, a % 5));
      ma[a / 5][a % 5] = pat(mode_l, a / 5, a % 5);
      mb[a / 5][a % 5] = pat(mode_r, a / 5, a % 5);
    end
    @(negedge clk);
    lhs_we = 1'b0; rhs_we = 1'b0;
  endtask

  // disturb: mid-run operand writes and a second start, both to be ignored
  task automatic run(input string tag, input bit disturb);
    int first_we = -1, writes = 0, order_ok = 1, done_at = -1, dones = 0;
    int idle_low_k0 = 0;
    for (int a = 0; a < 25; a++) seen[a] = 0;
    @(negedge clk);
    start = 1'b1;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      start = 1'b0; lhs_we = 1'b0; rhs_we = 1'b0;
      if (k == 0) idle_low_k0 = !idle;
      if (res_we) begin
        if (first_we < 0) first_we = k;
        if (int'(res_addr) != k - 4) order_ok = 0;
        if (res_addr < 25) begin got[res_addr] = res_wdata; seen[res_addr]++; end
        writes++;
      end
      if (done) begin
        dones++;
        if (done_at < 0) done_at = k;
        chk(idle == 1'b1, "R8", {tag, " idle with done"}, int'(idle), 1);
      end
      if (disturb && k == 10) begin
        start = 1'b1;
        lhs_we = 1'b1; lhs_addr = 5'd0; lhs_wdata = 8'd55;
        rhs_we = 1'b1; rhs_addr = 5'd12; rhs_wdata = 8'h80;
      end
    end
    chk(idle_low_k0 == 1, "R6", {tag, " idle low after accept"}, idle_low_k0, 1);
    chk(first_we == 4, "R7", {tag, " first write cycle"}, first_we, 4);
    chk(writes == 25, "R5", {tag, " write count"}, writes, 25);
    chk(order_ok == 1, "R5", {tag, " row-major order"}, order_ok, 1);
    chk(done_at == 29, "R8", {tag, " done cycle"}, done_at, 29);
    chk(dones == 1, "R8", {tag, " done pulses"}, dones, 1);
    for (int a = 0; a < 25; a++) begin
      logic [15:0] e;
      e = expect_at(a / 5, a % 5);
      chk(seen[a] == 1 && got[a] === e, "R4", {tag, " element"},
          int'(got[a]), int'(e));
    end
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0;
    lhs_we = 1'b0; rhs_we = 1'b0;
    lhs_addr = '0; rhs_addr = '0; lhs_wdata = '0; rhs_wdata = '0;
    #3;
    chk(idle == 1'b1 && done == 1'b0 && res_we == 1'b0, "R1", "during reset",
        {idle, done, res_we}, 3'b100);
    #30 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(idle == 1'b1 && done == 1'b0 && res_we == 1'b0, "R1", "after reset",
        {idle, done, res_we}, 3'b100);

    // Table of operand pattern pairs walked by one loop (R2, R4, R5, R7, R8)
    foreach (CASES[t]) begin
      load(int'(CASES[t][7:4]), int'(CASES[t][3:0]));
      run($sformatf("case%0d", t), 1'b0);
    end

    // R2: out-of-grid addresses write nothing
    load(3, 4);
    for (int a = 25; a < 32; a++) begin
      @(negedge clk);
      lhs_we = 1'b1; lhs_addr = 5'(a); lhs_wdata = 8'h7f;
      rhs_we = 1'b1; rhs_addr = 5'(a); rhs_wdata = 8'h81;
    end
    @(negedge clk);
    lhs_we = 1'b0; rhs_we = 1'b0;
    run("R2 out-of-range", 1'b0);

    // R3, R6: writes and start during a run are ignored
    run("R3 disturbed", 1'b1);
    repeat (12) begin
      @(negedge clk);
      chk(res_we == 1'b0 && idle == 1'b1, "R6", "no second run",
          {res_we, idle}, 2'b01);
    end
    // R9 and R3: rerun with no reload gives the original results
    run("R9 rerun", 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule